// File: doc/BRIEF.md
# Decode-Stage Interlock Controller

This block decides, every cycle, whether the instruction sitting in decode of a five-stage in-order integer pipeline may move on. It compares the source register numbers of the decode instruction with the destinations of the two older instructions in execute and memory access. It then drives the hold and bubble controls of the pipeline registers. The register file is written in the first half of a cycle and read in the second half, so the instruction in writeback never needs a comparison and has no inputs here.

Two stall styles are produced. An elastic stall holds the program counter and the fetch/decode register, while a NOP bubble is loaded into the decode/execute register so that older instructions keep draining. A global freeze, raised by an external memory-wait request, holds every pipeline register, writeback included. The freeze wins over an elastic stall. A mode input selects between a pipeline without bypass paths and one with full bypassing. With bypassing, only a load immediately followed by a consumer of its result still stalls.

Top module: `hazard_interlock`

## Requirements
- R1: With `fwd_en`=0, a match between a decode source and the execute-stage destination, when the execute instruction writes a register, sets `pc_hold`, `ifid_hold` and `idex_bubble` to 1 and leaves `freeze` at 0.
- R2: With `fwd_en`=0, a match against the memory-stage destination, when that instruction writes a register, causes the same elastic stall as R1.
- R3: A destination whose write-enable is 0 never causes a stall, whatever its register number.
- R4: Register number 0 is hardwired to zero and never causes a match.
- R5: When `id_uses_rs2`=0, the value on `id_rs2` is ignored.
- R6: With `fwd_en`=1, a match against a non-load instruction in execute or memory causes no stall.
- R7: With `fwd_en`=1, a load in execute (`ex_load`=1, `ex_we`=1) whose destination matches either used decode source causes an elastic stall, as in R1.
- R8: With `fwd_en`=1, a load in the memory stage that matches a decode source causes no stall.
- R9: `mem_wait`=1 sets `freeze`, `pc_hold` and `ifid_hold` to 1 and forces `idex_bubble` to 0, even when a hazard is present.
- R10: `pc_hold` and `ifid_hold` are always equal. `idex_bubble` is 1 only while they are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_en | input | 1 | 1 selects full-bypass mode |
| id_rs1 | input | RW | First source register of the decode instruction |
| id_rs2 | input | RW | Second source register of the decode instruction |
| id_uses_rs2 | input | 1 | Decode instruction reads its second source |
| ex_rd | input | RW | Destination of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | RW | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_wait | input | 1 | Memory system requests a wait |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| idex_bubble | output | 1 | Load a NOP into the decode/execute register |
| freeze | output | 1 | Hold all pipeline registers and suppress writeback |

## Verification
The block has no internal state. A wrong comparison or a wrong priority therefore shows at the hold and bubble outputs within the same cycle as the input pattern that triggers it. A missed match lets a consumer read a stale operand. A false match costs a spurious stall. Letting the bubble pass during a freeze would drop the frozen instruction from execute. The checks place each comparison path, each mode and the freeze priority under their own patterns, so every fault stays visible at the ports.

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
  parameter int RW = 5
) (
  input  logic          fwd_en,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_uses_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_wait,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          freeze
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic ex_live, mem_live, ex_hit, mem_hit, raw_stall;

  assign ex_live  = ex_we  && (ex_rd  != ZERO_REG);
  assign mem_live = mem_we && (mem_rd != ZERO_REG);

  assign ex_hit  = ex_live  && ((ex_rd  == id_rs1) || (id_uses_rs2 && ex_rd  == id_rs2));
  assign mem_hit = mem_live && ((mem_rd == id_rs1) || (id_uses_rs2 && mem_rd == id_rs2));

  assign raw_stall = fwd_en ? (ex_hit && ex_load) : (ex_hit || mem_hit);

  assign freeze      = mem_wait;
  assign pc_hold     = mem_wait || raw_stall;
  assign ifid_hold   = mem_wait || raw_stall;
  assign idex_bubble = raw_stall && !mem_wait;
endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
  parameter int RW = 5
) (
  input logic          fwd_en,
  input logic [RW-1:0] id_rs1,
  input logic [RW-1:0] id_rs2,
  input logic          id_uses_rs2,
  input logic          ex_we,
  input logic          ex_load,
  input logic          mem_we,
  input logic          mem_wait,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          idex_bubble,
  input logic          freeze
);
  always_comb begin
    p_wait_holds_all_r9: assert (!mem_wait || (freeze && pc_hold && ifid_hold && !idex_bubble));
    p_hold_pair_r10: assert (pc_hold == ifid_hold);
    p_bubble_needs_hold_r10: assert (!idex_bubble || pc_hold);
    p_no_writer_r3: assert (mem_wait || ex_we || mem_we || !pc_hold);
    p_zero_sources_r4: assert (mem_wait || id_rs1 != '0 || (id_uses_rs2 && id_rs2 != '0) || !pc_hold);
    p_fwd_nonload_r6: assert (mem_wait || !fwd_en || ex_load || !pc_hold);
  end
endmodule

bind hazard_interlock hazard_interlock_chk #(.RW(RW)) u_chk (
  .fwd_en(fwd_en), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_uses_rs2(id_uses_rs2),
  .ex_we(ex_we), .ex_load(ex_load), .mem_we(mem_we), .mem_wait(mem_wait),
  .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .freeze(freeze)
);

// File: tb/hazard_interlock_bench.sv
`timescale 1ns/1ps
module hazard_interlock_bench;
  localparam int RW = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_en, id_uses_rs2, ex_we, ex_load, mem_we, mem_wait;
  logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic pc_hold, ifid_hold, idex_bubble, freeze;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hazard_interlock #(.RW(RW)) u_hazard_interlock (
    .fwd_en(fwd_en), .id_rs1(id_rs1), .id_rs2(id_rs2), .id_uses_rs2(id_uses_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_wait(mem_wait), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .idex_bubble(idex_bubble), .freeze(freeze)
  );

  task automatic idle();
    fwd_en = 0; id_rs1 = 0; id_rs2 = 0; id_uses_rs2 = 0;
    ex_rd = 0; ex_we = 0; ex_load = 0; mem_rd = 0; mem_we = 0; mem_wait = 0;
  endtask

  task automatic apply(input bit fwd, input int s1, input int s2, input bit u2,
                       input int erd, input bit ewe, input bit eld,
                       input int mrd, input bit mwe, input bit wt);
    @(negedge clk);
    fwd_en = fwd; id_rs1 = RW'(s1); id_rs2 = RW'(s2); id_uses_rs2 = u2;
    ex_rd = RW'(erd); ex_we = ewe; ex_load = eld;
    mem_rd = RW'(mrd); mem_we = mwe; mem_wait = wt;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {pc_hold, ifid_hold, idex_bubble, freeze};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b expected=%b", req, got, exp);
    end
  endtask

  localparam logic [3:0] GO = 4'b0000, ELASTIC = 4'b1110, FROZEN = 4'b1101;

  task automatic t_reset_state();
    @(negedge clk); idle(); #1;
    expect_out("reset R10", GO);
  endtask

  task automatic t_ex_match_r1();
    apply(0, 3, 0, 0, 3, 1, 0, 0, 0, 0); expect_out("R1 rs1 vs ex", ELASTIC);
    apply(0, 4, 7, 1, 7, 1, 0, 0, 0, 0); expect_out("R1 rs2 vs ex", ELASTIC);
  endtask

  task automatic t_mem_match_r2();
    apply(0, 9, 0, 0, 1, 1, 0, 9, 1, 0); expect_out("R2 rs1 vs mem", ELASTIC);
    apply(0, 1, 12, 1, 2, 1, 0, 12, 1, 0); expect_out("R2 rs2 vs mem", ELASTIC);
  endtask

  task automatic t_no_write_r3();
    apply(0, 6, 6, 1, 6, 0, 1, 6, 0, 0); expect_out("R3 we low", GO);
  endtask

  task automatic t_reg_zero_r4();
    apply(0, 0, 0, 1, 0, 1, 0, 0, 1, 0); expect_out("R4 x0 no-fwd", GO);
    apply(1, 0, 5, 1, 0, 1, 1, 0, 1, 0); expect_out("R4 x0 load", GO);
  endtask

  task automatic t_unused_rs2_r5();
    apply(0, 2, 8, 0, 8, 1, 0, 8, 1, 0); expect_out("R5 rs2 ignored", GO);
    apply(1, 2, 8, 0, 8, 1, 1, 0, 0, 0); expect_out("R5 rs2 ignored load", GO);
  endtask

  task automatic t_fwd_alu_r6();
    apply(1, 3, 4, 1, 3, 1, 0, 4, 1, 0); expect_out("R6 bypassed", GO);
  endtask

  task automatic t_load_use_r7();
    apply(1, 10, 0, 0, 10, 1, 1, 0, 0, 0); expect_out("R7 load rs1", ELASTIC);
    apply(1, 1, 31, 1, 31, 1, 1, 0, 0, 0); expect_out("R7 load rs2", ELASTIC);
    apply(1, 1, 31, 1, 0, 0, 0, 31, 1, 0); expect_out("R7 released next cycle", GO);
  endtask

  task automatic t_load_in_mem_r8();
    apply(1, 11, 0, 0, 2, 1, 0, 11, 1, 0); expect_out("R8 load in mem", GO);
  endtask

  task automatic t_freeze_r9();
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 1); expect_out("R9 wait alone", FROZEN);
    apply(0, 5, 0, 0, 5, 1, 0, 0, 0, 1); expect_out("R9 wait over raw", FROZEN);
    apply(1, 5, 0, 0, 5, 1, 1, 0, 0, 1); expect_out("R9 wait over load-use", FROZEN);
    apply(1, 5, 0, 0, 5, 1, 1, 0, 0, 0); expect_out("R9 wait released R10", ELASTIC);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_ex_match_r1();
    t_mem_match_r2();
    t_no_write_r3();
    t_reg_zero_r4();
    t_unused_rs2_r5();
    t_fwd_alu_r6();
    t_load_use_r7();
    t_load_in_mem_r8();
    t_freeze_r9();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got=timeout expected=finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule